// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block decides whether an interrupt notification addressed to a virtual processor should be presented on one hardware thread, and if so at which privilege ring. A request carries a target block and index, a format flag, an ignore flag and a logical-server identifier. The thread side supplies its four context words (user, OS, pool, physical) and its hardware identity, a chip block id and a processor id. One cycle after a request is accepted the block reports a response strobe, a hit flag, the ring code of the hit and a flag for a request kind it does not serve.

Each context word is a 32-bit vector held most significant byte first: its first byte sits in bits [31:24]. The top bit of each word is that ring's valid flag. The target CAM value is the block in bits [27:24] and the index in bits [23:0]. The physical ring keeps no stored CAM value. Its CAM line is formed from the chip block id and a thread field derived from the processor id. In index-matching mode the physical, pool and OS rings are tried in that order, and the first that matches wins. In user mode only the user ring can be reported, and only when the OS ring also matches.

Top module: `ctx_cam_matcher`

## Requirements
- R1: While `rst_n` is low at a rising edge, `resp_valid`, `hit` and `unsup` are 0 after that edge, whatever the request inputs are.
- R2: `resp_valid` equals the `req_valid` of the previous cycle. `hit` and `unsup` are 0 whenever `resp_valid` is 0.
- R3: With `req_fmt`=0 and `req_ign`=0, the physical ring matches when `ctx_phys[31]`=1 and {`req_blk`,`req_idx`} equals {`hw_blk`, 24-bit value 0x80 | (`hw_pid` & 0x7F)}. A match gives `hit`=1 and `hit_ring`=3.
- R4: With `req_fmt`=0 and `req_ign`=0, the pool ring matches when `ctx_pool[31]`=1 and `ctx_pool[27:0]` equals {`req_blk`,`req_idx`}. A match gives `hit_ring`=2.
- R5: With `req_fmt`=0 and `req_ign`=0, the OS ring matches when `ctx_os[31]`=1 and `ctx_os[27:0]` equals {`req_blk`,`req_idx`}. A match gives `hit_ring`=1.
- R6: When more than one of those rings matches, physical is reported before pool, and pool before OS.
- R7: With `req_fmt`=1, `hit`=1 with `hit_ring`=0 exactly when `ctx_os[31]`=1, `ctx_os[27:0]` equals the target, `ctx_user[31]`=1 and `ctx_user[23:0]` equals `req_ls`. The pool word, the physical word and `req_ign` have no effect in this mode.
- R8: With `req_fmt`=0 and `req_ign`=1, the response has `unsup`=1 and `hit`=0, even when a ring would otherwise match.
- R9: A ring whose valid bit (bit 31) is 0 never matches, even when its CAM field equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_blk | input | 4 | Target block |
| req_idx | input | 24 | Target index |
| req_fmt | input | 1 | 0: index matching, 1: user-level matching |
| req_ign | input | 1 | Index low-bit ignore request (not served) |
| req_ls | input | 24 | Requested logical-server id |
| ctx_user | input | 32 | User ring context word |
| ctx_os | input | 32 | OS ring context word |
| ctx_pool | input | 32 | Pool ring context word |
| ctx_phys | input | 32 | Physical ring context word (only bit 31 used) |
| hw_blk | input | 4 | Chip block id of the thread |
| hw_pid | input | 16 | Processor id of the thread |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| hit | output | 1 | A ring matched |
| hit_ring | output | 2 | Matched ring: 0 user, 1 OS, 2 pool, 3 physical; valid only with `hit` |
| unsup | output | 1 | Request kind not served, no match given |

## Verification
A wrong comparison or priority shows on the cycle right after the request. The most visible cases are a wrong `hit_ring` when several rings hold the same CAM value, and a missed physical hit when processor id bits above bit 6 are set. A stale output register shows as a response that does not follow `req_valid` by exactly one cycle. A user-mode mix-up shows as a hit while the OS ring is invalid, or as a pool or physical word changing a user-mode answer. The bench applies a new request every cycle, so each of these faults appears on a single response.

// File: rtl/ctx_cam_pkg.sv
// Package: ring codes shared by the CAM matcher and its sub-blocks.
// Assumes a two-bit ring code; the physical ring has the highest priority.
package ctx_cam_pkg;
    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;
endpackage

// File: rtl/ctx_hw_cam.sv
// Module: ctx_hw_cam
// Builds the CAM line of the physical ring from the thread's hardware identity.
// Assumes 7-bit thread-id mode: the index is a marker bit above the low TID_W pid bits.
module ctx_hw_cam #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 24,
    parameter int PID_W = 16,
    parameter int TID_W = 7
) (
    input  logic [BLK_W-1:0]       hw_blk,
    input  logic [PID_W-1:0]       hw_pid,
    output logic [BLK_W+IDX_W-1:0] hw_cam
);
    localparam int PAD_W = IDX_W - TID_W - 1;

    logic unused_pid_hi;

    // Purpose: keep the pid bits above the thread field visibly unused.
    assign unused_pid_hi = ^hw_pid[PID_W-1:TID_W];

    // Purpose: concatenate block, zero padding, marker bit and thread id.
    assign hw_cam = {hw_blk, {PAD_W{1'b0}}, 1'b1, hw_pid[TID_W-1:0]};
endmodule

// File: rtl/ctx_ring_cmp.sv
// Module: ctx_ring_cmp
// Compares one ring's CAM reference against the target, qualified by its valid flag.
// Assumes both values are already in packed block/index form.
module ctx_ring_cmp #(
    parameter int CAM_W = 28
) (
    input  logic             ring_vld,
    input  logic [CAM_W-1:0] ring_cam,
    input  logic [CAM_W-1:0] tgt_cam,
    output logic             ring_hit
);
    // Purpose: a ring matches only when it is valid and its CAM value is equal.
    assign ring_hit = ring_vld && (ring_cam == tgt_cam);
endmodule

// File: rtl/ctx_ring_pick.sv
// Module: ctx_ring_pick
// Chooses the reported ring from the per-ring hits and the request mode.
// Assumes cam_hit[0]=OS, [1]=pool, [2]=physical; user_ok already includes the OS match.
module ctx_ring_pick
    import ctx_cam_pkg::*;
(
    input  logic       req_fmt,
    input  logic       req_ign,
    input  logic [2:0] cam_hit,
    input  logic       user_ok,
    output logic       any_hit,
    output ring_e      ring,
    output logic       unsup
);
    // Purpose: user mode first, then the unsupported ignore mode, then fixed priority.
    always_comb begin
        any_hit = 1'b0;
        ring    = RING_USER;
        unsup   = 1'b0;
        if (req_fmt) begin
            any_hit = user_ok;
        end else if (req_ign) begin
            unsup = 1'b1;
        end else if (cam_hit[2]) begin
            any_hit = 1'b1;
            ring    = RING_PHYS;
        end else if (cam_hit[1]) begin
            any_hit = 1'b1;
            ring    = RING_POOL;
        end else if (cam_hit[0]) begin
            any_hit = 1'b1;
            ring    = RING_OS;
        end
    end

    // Purpose: an unserved request never reports a hit.
    always_comb begin
        // R8
        unsup_excl_chk: assert (!(unsup && any_hit));
    end
endmodule

// File: rtl/ctx_cam_matcher.sv
// Module: ctx_cam_matcher
// Matches a notification target against a thread's four context rings and
// registers the verdict, giving the answer one cycle after the request.
// Assumes big-endian context words (first byte in the top bits), the valid flag in
// the top bit, and CAM fields in the low BLK_W+IDX_W bits; CAM_W must be below WORD_W.
module ctx_cam_matcher
    import ctx_cam_pkg::*;
#(
    parameter int BLK_W  = 4,
    parameter int IDX_W  = 24,
    parameter int PID_W  = 16,
    parameter int TID_W  = 7,
    parameter int LS_W   = 24,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_fmt,
    input  logic              req_ign,
    input  logic [LS_W-1:0]   req_ls,
    input  logic [WORD_W-1:0] ctx_user,
    input  logic [WORD_W-1:0] ctx_os,
    input  logic [WORD_W-1:0] ctx_pool,
    input  logic [WORD_W-1:0] ctx_phys,
    input  logic [BLK_W-1:0]  hw_blk,
    input  logic [PID_W-1:0]  hw_pid,
    output logic              resp_valid,
    output logic              hit,
    output logic [1:0]        hit_ring,
    output logic              unsup
);
    localparam int CAM_W  = BLK_W + IDX_W;
    localparam int VBIT   = WORD_W - 1;
    localparam int NRINGS = 3;

    logic [CAM_W-1:0] tgt_cam;
    logic [CAM_W-1:0] hw_cam;
    logic [CAM_W-1:0] ref_cam [NRINGS];
    logic             ref_vld [NRINGS];
    logic [2:0]       cam_hit;
    logic             user_ok;
    logic             any_hit;
    ring_e            pick_ring;
    logic             pick_unsup;
    logic             unused_words;

    // Purpose: pack the request target into one CAM value.
    assign tgt_cam = {req_blk, req_idx};

    // Purpose: mark the context bits that no ring decodes.
    assign unused_words = ^{ctx_user[VBIT-1:LS_W], ctx_os[VBIT-1:CAM_W],
                            ctx_pool[VBIT-1:CAM_W], ctx_phys[VBIT-1:0]};

    ctx_hw_cam #(
        .BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W), .TID_W(TID_W)
    ) u_hw_cam (
        .hw_blk(hw_blk),
        .hw_pid(hw_pid),
        .hw_cam(hw_cam)
    );

    // Purpose: route each index-matched ring's valid flag and reference CAM.
    always_comb begin
        ref_vld[0] = ctx_os[VBIT];
        ref_cam[0] = ctx_os[CAM_W-1:0];
        ref_vld[1] = ctx_pool[VBIT];
        ref_cam[1] = ctx_pool[CAM_W-1:0];
        ref_vld[2] = ctx_phys[VBIT];
        ref_cam[2] = hw_cam;
    end

    for (genvar g = 0; g < NRINGS; g++) begin : g_ring
        ctx_ring_cmp #(.CAM_W(CAM_W)) u_cmp (
            .ring_vld(ref_vld[g]),
            .ring_cam(ref_cam[g]),
            .tgt_cam (tgt_cam),
            .ring_hit(cam_hit[g])
        );
    end

    // Purpose: user ring needs the OS ring match plus its own valid flag and server id.
    assign user_ok = cam_hit[0] && ctx_user[VBIT] && (ctx_user[LS_W-1:0] == req_ls);

    ctx_ring_pick u_pick (
        .req_fmt(req_fmt),
        .req_ign(req_ign),
        .cam_hit(cam_hit),
        .user_ok(user_ok),
        .any_hit(any_hit),
        .ring   (pick_ring),
        .unsup  (pick_unsup)
    );

    // Purpose: register the verdict; hit and unsup are gated by the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            hit        <= 1'b0;
            hit_ring   <= 2'd0;
            unsup      <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            hit        <= req_valid && any_hit;
            hit_ring   <= pick_ring;
            unsup      <= req_valid && pick_unsup;
        end
    end

    // R2
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R2
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !hit && !unsup);

    // R3
    phys_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_fmt && !req_ign && cam_hit[2] |=> hit && hit_ring == 2'd3);

    // R7
    user_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && hit_ring == 2'd0 |-> $past(req_fmt) && $past(cam_hit[0]));

    // R8
    ignore_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_fmt && req_ign |=> unsup && !hit);
endmodule

// File: tb/ctx_cam_matcher_bench.sv
module ctx_cam_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_fmt, req_ign;
    logic [3:0]  req_blk, hw_blk;
    logic [23:0] req_idx, req_ls;
    logic [31:0] ctx_user, ctx_os, ctx_pool, ctx_phys;
    logic [15:0] hw_pid;
    logic        resp_valid, hit, unsup;
    logic [1:0]  hit_ring;

    // next-stimulus shadow copies, applied after each check
    logic        n_rst_n = 1'b0, n_valid = 1'b0, n_fmt = 1'b0, n_ign = 1'b0;
    logic [3:0]  n_blk = '0, n_hwblk = '0;
    logic [23:0] n_idx = '0, n_ls = '0;
    logic [31:0] n_user = '0, n_os = '0, n_pool = '0, n_phys = '0;
    logic [15:0] n_pid = '0;

    bit    e_rv, e_hit, e_unsup;
    int    e_ring;
    string e_tag = "R1";
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    ctx_cam_matcher u_ctx_cam_matcher (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
        .req_idx(req_idx), .req_fmt(req_fmt), .req_ign(req_ign), .req_ls(req_ls),
        .ctx_user(ctx_user), .ctx_os(ctx_os), .ctx_pool(ctx_pool), .ctx_phys(ctx_phys),
        .hw_blk(hw_blk), .hw_pid(hw_pid), .resp_valid(resp_valid), .hit(hit),
        .hit_ring(hit_ring), .unsup(unsup)
    );

    // behavioural reference: answer for the stimulus currently on the inputs
    task automatic predict();
        longint tgt, hwc;
        bit os_m, pool_m, phys_m;
        tgt = (longint'(req_blk) << 24) | longint'(req_idx);
        hwc = (longint'(hw_blk) << 24) + 128 + (hw_pid % 128);
        os_m   = ctx_os[31]   && ((ctx_os   & 32'h0FFF_FFFF) == tgt);
        pool_m = ctx_pool[31] && ((ctx_pool & 32'h0FFF_FFFF) == tgt);
        phys_m = ctx_phys[31] && (hwc == tgt);
        e_rv = rst_n && req_valid;
        e_hit = 0; e_unsup = 0; e_ring = 0;
        if (e_rv) begin
            if (req_fmt) begin
                e_hit = os_m && ctx_user[31] && ((ctx_user & 32'h00FF_FFFF) == req_ls);
                e_ring = 0;
            end else if (req_ign) e_unsup = 1;
            else if (phys_m) begin e_hit = 1; e_ring = 3; end
            else if (pool_m) begin e_hit = 1; e_ring = 2; end
            else if (os_m)   begin e_hit = 1; e_ring = 1; end
        end
    endtask

    // check the pending expectation, then apply the next stimulus
    task automatic step(input string tag);
        @(negedge clk);
        if (done) return;
        checks++;
        if (resp_valid !== e_rv || hit !== e_hit || unsup !== e_unsup ||
            (e_hit && hit_ring !== e_ring[1:0])) begin
            errors++;
            $display("FAIL %s: got rv=%0b hit=%0b ring=%0d unsup=%0b, expected rv=%0b hit=%0b ring=%0d unsup=%0b",
                     e_tag, resp_valid, hit, hit_ring, unsup, e_rv, e_hit, e_ring, e_unsup);
        end
        rst_n = n_rst_n; req_valid = n_valid; req_blk = n_blk; req_idx = n_idx;
        req_fmt = n_fmt; req_ign = n_ign; req_ls = n_ls; ctx_user = n_user;
        ctx_os = n_os; ctx_pool = n_pool; ctx_phys = n_phys; hw_blk = n_hwblk; hw_pid = n_pid;
        predict();
        e_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; req_valid = 0; req_blk = 0; req_idx = 0; req_fmt = 0; req_ign = 0;
        req_ls = 0; ctx_user = 0; ctx_os = 0; ctx_pool = 0; ctx_phys = 0;
        hw_blk = 0; hw_pid = 0;
        e_rv = 0; e_hit = 0; e_unsup = 0; e_ring = 0;
        // R1: request held high during reset, a phys match present
        n_valid = 1; n_hwblk = 4'h5; n_pid = 16'h01A5; n_blk = 4'h5; n_idx = 24'h0000A5;
        n_phys = 32'h8000_0000;
        step("R1"); step("R1"); step("R1");
        n_rst_n = 1;
        // R3: phys match with pid upper bits set (0x1A5 -> field 0xA5)
        step("R3");
        // R3: index without the marker bit does not match phys
        n_idx = 24'h000025; step("R3");
        // R9: phys invalid with equal CAM
        n_idx = 24'h0000A5; n_phys = 32'h0; step("R9");
        // R4: pool match
        n_blk = 4'h2; n_idx = 24'h123456; n_pool = 32'h8212_3456; step("R4");
        // R5: OS match
        n_pool = 32'h0; n_os = 32'h8212_3456; step("R5");
        // R9: OS invalid with equal CAM field
        n_os = 32'h0212_3456; step("R9");
        // R6: pool and OS both match -> pool
        n_os = 32'h8212_3456; n_pool = 32'h8212_3456; step("R6");
        // R6: phys, pool, OS all match -> phys
        n_hwblk = 4'h2; n_pid = 16'hFF33; n_blk = 4'h2; n_idx = 24'h0000B3;
        n_os = 32'h8200_00B3; n_pool = 32'h8200_00B3; n_phys = 32'h8000_0000; step("R6");
        // R2: no request -> no response even with matches
        n_valid = 0; step("R2");
        n_valid = 1; step("R2");
        // R8: ignore mode with matches present
        n_ign = 1; step("R8");
        // R7: user mode hit, ignore flag has no effect
        n_fmt = 1; n_user = 32'h8000_0777; n_ls = 24'h000777; step("R7");
        // R7: server id mismatch
        n_ls = 24'h000778; step("R7");
        // R7: user ring invalid
        n_ls = 24'h000777; n_user = 32'h0000_0777; step("R7");
        // R7: OS invalid blocks user hit although pool and phys match
        n_user = 32'h8000_0777; n_os = 32'h0200_00B3; step("R7");
        // R7: OS CAM differs
        n_os = 32'h8200_00B4; step("R7");
        // R7: back to hit, ign cleared
        n_os = 32'h8200_00B3; n_ign = 0; step("R7");
        // R5: index mode, only OS left
        n_fmt = 0; n_pool = 32'h0; n_phys = 32'h0; step("R5");
        // R4: different block in pool does not match
        n_pool = 32'h8300_00B3; step("R4");
        n_valid = 0; step("R2");
        step("R2");
        finish_run();
    end
endmodule